// File: doc/BRIEF.md
# Leaky Eligibility Trace Updater

This block refreshes one stored per-synapse eligibility trace at a time. A client hands it a trace address and a flag saying whether a spike-timing event was seen for that synapse. The block fetches the 36-bit signed fixed-point trace from an external synchronous trace memory and applies a leak formed by an arithmetic right shift. If the flag is set, it then adds a fixed increment, clamps the result to the 36-bit signed range, and stores it back at the address it was read from. When the write has been issued, the block emits a one-cycle done pulse.

The arithmetic matches a membrane-potential leak, but the result is never compared against a threshold and nothing like a spike leaves the block. The memory port issues a read, takes the data after a fixed, parameterised number of cycles, and later issues the write. Only one update is in flight at a time. The request port uses a valid/ready handshake, and ready stays low for the whole read-modify-write.

Top module: `trace_leak_updater`

## Requirements
- R1: After synchronous reset, req_ready is 1 and mem_rd_en, mem_wr_en and done are 0.
- R2: Without an event, a trace c is replaced by c − (c >>> LEAK_SHIFT), and the write goes to the same address as the read (LEAK_SHIFT = 4 in the bench, e.g. 1600 becomes 1500).
- R3: The shift is arithmetic, so negative traces move toward zero: −17 becomes −15 and −1 becomes 0 with LEAK_SHIFT = 4.
- R4: With req_event = 1, the value INCR is added after the leak, so a zero trace becomes INCR.
- R5: A sum above 2^35 − 1 is written as 2^35 − 1 and never wraps.
- R6: One cycle after a request is accepted, mem_rd_en is high for exactly one cycle with mem_addr equal to the request address.
- R7: mem_wr_en rises RD_LAT + 1 cycles after the read cycle and lasts one cycle. done is high for exactly the cycle after it.
- R8: req_ready is 0 from the cycle after acceptance through the done cycle and returns to 1 the cycle after done. A req_valid raised while req_ready is 0 starts no memory access.
- R9: Each request makes exactly one read and one write, and no other trace memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Trace address to update |
| req_event | input | 1 | Add the increment after the leak |
| mem_rd_en | output | 1 | Trace memory read strobe |
| mem_wr_en | output | 1 | Trace memory write strobe |
| mem_addr | output | ADDR_W | Trace memory address |
| mem_wdata | output | TRACE_W | Updated trace value |
| mem_rdata | input | TRACE_W | Trace data, valid RD_LAT cycles after the read |
| done | output | 1 | One-cycle pulse when the update is complete |

## Verification
If the latency counter is wrong, the write is either sampled from stale read data or lands on a different cycle. Either fault shows up at mem_wr_en or in mem_wdata within RD_LAT + 2 cycles of acceptance. A fault in the leak or clamp path shows up directly in the written word on the same write cycle, so the bench compares every write against its own model. A stuck handshake state shows up as a missing done, a wrong ready value, or an extra read or write the cycle after done. A final sweep of the whole trace memory catches any stray write.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/trace_leak_alu.sv
module trace_leak_alu #(
  parameter int TRACE_W = 36,
  parameter int LEAK_SHIFT = 4,
  parameter logic signed [TRACE_W-1:0] INCR = 36'sd4096
) (
  input  logic signed [TRACE_W-1:0] cur_i,
  input  logic                      event_i,
  output logic signed [TRACE_W-1:0] nxt_o
);
  localparam int EXT_W = TRACE_W + 1;
  localparam logic signed [TRACE_W-1:0] MAX_V = {1'b0, {(TRACE_W-1){1'b1}}};
  localparam logic signed [TRACE_W-1:0] MIN_V = {1'b1, {(TRACE_W-1){1'b0}}};

  logic signed [TRACE_W-1:0] shifted;
  logic signed [TRACE_W-1:0] leaked;
  logic signed [EXT_W-1:0]   sum;
  logic signed [EXT_W-1:0]   addend;

  always_comb begin
    shifted = cur_i >>> LEAK_SHIFT;
    leaked  = cur_i - shifted;
    addend  = event_i ? {INCR[TRACE_W-1], INCR} : '0;
    sum     = {leaked[TRACE_W-1], leaked} + addend;
    if (sum[EXT_W-1] != sum[EXT_W-2])
      nxt_o = sum[EXT_W-1] ? MIN_V : MAX_V;
    else
      nxt_o = sum[TRACE_W-1:0];
  end
endmodule

// File: rtl/trace_rmw_seq.sv
module trace_rmw_seq
  import trace_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int TRACE_W = 36,
  parameter int RD_LAT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_event,
  input  logic [TRACE_W-1:0] new_value,
  output logic               req_ready,
  output logic               event_q,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [TRACE_W-1:0] mem_wdata,
  output logic               done
);
  localparam int CNT_W = $clog2(RD_LAT + 1);
  localparam logic [CNT_W-1:0] LAT_LAST = CNT_W'(RD_LAT);

  seq_state_t       state;
  logic [CNT_W-1:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      event_q   <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      lat_cnt   <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      done      <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            mem_addr  <= req_addr;
            event_q   <= req_event;
            mem_rd_en <= 1'b1;
            req_ready <= 1'b0;
            lat_cnt   <= '0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (lat_cnt == LAT_LAST) begin
            mem_wdata <= new_value;
            mem_wr_en <= 1'b1;
            state     <= ST_WRITE;
          end else begin
            lat_cnt <= lat_cnt + 1'b1;
          end
        end
        ST_WRITE: begin
          done  <= 1'b1;
          state <= ST_DONE;
        end
        default: begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/trace_leak_updater.sv
module trace_leak_updater #(
  parameter int ADDR_W = 23,
  parameter int TRACE_W = 36,
  parameter int LEAK_SHIFT = 4,
  parameter logic signed [TRACE_W-1:0] INCR = 36'sd4096,
  parameter int RD_LAT = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_event,
  output logic               mem_rd_en,
  output logic               mem_wr_en,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [TRACE_W-1:0] mem_wdata,
  input  logic [TRACE_W-1:0] mem_rdata,
  output logic               done
);
  logic                      event_q;
  logic signed [TRACE_W-1:0] next_trace;

  trace_leak_alu #(
    .TRACE_W(TRACE_W), .LEAK_SHIFT(LEAK_SHIFT), .INCR(INCR)
  ) u_alu (
    .cur_i(mem_rdata), .event_i(event_q), .nxt_o(next_trace)
  );

  trace_rmw_seq #(
    .ADDR_W(ADDR_W), .TRACE_W(TRACE_W), .RD_LAT(RD_LAT)
  ) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_event(req_event), .new_value(next_trace), .req_ready(req_ready),
    .event_q(event_q), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );
endmodule

// File: rtl/trace_leak_updater_chk.sv
module trace_leak_updater_chk #(
  parameter int ADDR_W = 23,
  parameter int TRACE_W = 36
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               mem_rd_en,
  input logic               mem_wr_en,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic               done
);
  logic [ADDR_W-1:0] rd_addr_q;
  always_ff @(posedge clk) begin
    if (rst) rd_addr_q <= '0;
    else if (mem_rd_en) rd_addr_q <= mem_addr;
  end

  assert_rd_single_R6: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  assert_rd_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd_en && mem_addr == $past(req_addr)));
  assert_done_after_wr_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |=> (done && !mem_wr_en));
  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  assert_not_ready_in_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !req_ready);
  assert_ready_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> req_ready);
  assert_wr_same_addr_R2: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> mem_addr == rd_addr_q);
  assert_rd_wr_apart_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));
endmodule

bind trace_leak_updater trace_leak_updater_chk #(
  .ADDR_W(ADDR_W), .TRACE_W(TRACE_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
  .mem_addr(mem_addr), .done(done)
);

// File: tb/trace_leak_updater_tb.sv
module trace_leak_updater_tb;
  localparam int ADDR_W = 8;
  localparam int TW = 36;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SHIFT = 4;
  localparam int RD_LAT = 2;
  localparam longint INCR_V = 64'sd3000000000;
  localparam longint MAXV = (64'sd1 <<< 35) - 1;
  localparam longint MINV = -(64'sd1 <<< 35);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_event = 1'b0;
  logic mem_rd_en, mem_wr_en, done;
  logic [ADDR_W-1:0] mem_addr;
  logic [TW-1:0] mem_wdata;
  logic [TW-1:0] mem_rdata;

  logic [TW-1:0] mem [DEPTH];
  logic [TW-1:0] pipe [RD_LAT];
  longint shadow [DEPTH];
  int checks = 0;
  int errors = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  always #10 clk = ~clk;

  trace_leak_updater #(
    .ADDR_W(ADDR_W), .TRACE_W(TW), .LEAK_SHIFT(SHIFT),
    .INCR(INCR_V[TW-1:0]), .RD_LAT(RD_LAT)
  ) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_event(req_event), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .done(done)
  );

  always @(posedge clk) begin
    pipe[0] <= mem_rd_en ? mem[mem_addr] : 'x;
    for (int i = 1; i < RD_LAT; i++) pipe[i] <= pipe[i-1];
    if (mem_wr_en) mem[mem_addr] <= mem_wdata;
    if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    if (mem_wr_en) wr_cnt <= wr_cnt + 1;
  end
  assign mem_rdata = pipe[RD_LAT-1];

  function automatic longint model(longint c, bit ev);
    longint r = c - (c >>> SHIFT);
    if (ev) r = r + INCR_V;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preset(int a, longint v);
    mem[a] = v[TW-1:0];
    shadow[a] = v;
  endtask

  task automatic run_req(int a, bit ev, bit poke, string tag);
    longint exp = model(shadow[a], ev);
    int rd0 = rd_cnt;
    int wr0 = wr_cnt;
    req_valid = 1'b1; req_addr = a[ADDR_W-1:0]; req_event = ev;
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_rd_en && mem_addr == a[ADDR_W-1:0], "R6", longint'(mem_addr), a);
    for (int k = 2; k <= RD_LAT + 1; k++) begin
      @(negedge clk);
      if (k == 3) req_valid = 1'b0;
      chk(!mem_wr_en && !req_ready && !mem_rd_en, "R8", req_ready, 0);
      if (k == 2 && poke) begin
        req_valid = 1'b1; req_addr = a[ADDR_W-1:0] ^ 8'h55;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_wr_en && mem_addr == a[ADDR_W-1:0], "R7", mem_wr_en, 1);
    chk(longint'($signed(mem_wdata)) == exp, tag, longint'($signed(mem_wdata)), exp);
    @(negedge clk);
    chk(done && !req_ready, "R7", done, 1);
    @(negedge clk);
    chk(!done && req_ready && !mem_rd_en, "R8", req_ready, 1);
    chk(rd_cnt - rd0 == 1 && wr_cnt - wr0 == 1, "R9", rd_cnt - rd0, 1);
    shadow[a] = exp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rv;
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      rv = {$urandom, $urandom};
      preset(i, longint'($signed(rv[TW-1:0])));
    end
    for (int i = 0; i < RD_LAT; i++) pipe[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !mem_rd_en && !mem_wr_en && !done, "R1", req_ready, 1);

    preset(10, 1600);
    run_req(10, 1'b0, 1'b0, "R2");
    chk(shadow[10] == 1500, "R2", shadow[10], 1500);
    preset(11, -17);
    run_req(11, 1'b0, 1'b0, "R3");
    chk(shadow[11] == -15, "R3", shadow[11], -15);
    preset(12, -1);
    run_req(12, 1'b0, 1'b0, "R3");
    preset(13, 0);
    run_req(13, 1'b1, 1'b0, "R4");
    chk(shadow[13] == INCR_V, "R4", shadow[13], INCR_V);
    preset(14, MAXV);
    run_req(14, 1'b1, 1'b0, "R5");
    chk(shadow[14] == MAXV, "R5", shadow[14], MAXV);
    preset(15, 0);
    run_req(15, 1'b0, 1'b1, "R8");

    for (int n = 0; n < 80; n++) begin
      int a = int'($urandom_range(DEPTH - 1, 0));
      run_req(a, 1'($urandom), 1'($urandom_range(3, 0) == 0), "R2");
    end

    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++)
        if (longint'($signed(mem[i])) != shadow[i]) bad++;
      chk(bad == 0, "R9", bad, 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule